// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block steps a vector operation through its elements under a per-element enable mask, one element per clock. It holds the mask, one bit per element, and produces for the register file the index of each issued element and a write-enable for its result. Where a mask bit is clear, that element's operation must leave the destination register unchanged.

Two issue modes are offered, chosen at start. In full-sweep mode every element below the vector length is issued in ascending order, and the write-enable follows the mask bit, so masked-off elements still take a cycle but write nothing. In skip mode the sequencer looks ahead in the mask and issues only the enabled elements, so a sparse mask finishes in as many cycles as it has set bits. The mask is written either by a fill command that enables every element or by loading a per-element comparison result taken from the arithmetic side. The arithmetic itself lies outside the block.

Top module: `mvx_seq`

## Requirements
- R1: After reset `elem_vld_o`, `wr_en_o`, `done_o` and `busy_o` are low and `mask_o` is all ones.
- R2: While idle, `fill_i` makes every bit of `mask_o` one at the next clock edge.
- R3: While idle, `cmp_load_i` copies `cmp_res_i` into `mask_o` at the next clock edge; when `fill_i` and `cmp_load_i` come together, the fill wins.
- R4: While `busy_o` is high, mask commands are ignored and `mask_o` does not change.
- R5: In full-sweep mode (`dense_i` = 0 at start) elements 0 to len-1 appear on `elem_idx_o` on consecutive cycles, the first in the cycle after the start edge, with `wr_en_o` equal to the mask bit of that element.
- R6: In skip mode (`dense_i` = 1 at start) only elements whose mask bit is one are issued, in ascending order on consecutive cycles, each with `wr_en_o` high.
- R7: Mask bits at or above the vector length have no effect: such elements are never issued in skip mode.
- R8: `done_o` pulses for one cycle in the cycle after the last issued element; with length zero, or in skip mode with no enabled element, it comes in the cycle right after the start edge.
- R9: A `vlen_i` larger than VLMAX is treated as VLMAX.
- R10: `start_i` is ignored while `busy_o` is high; the running operation keeps the length, mode and mask it was started with.
- R11: `wr_en_o` is high only together with `elem_vld_o`, and `done_o` never coincides with `elem_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (taken when idle) |
| dense_i | input | 1 | Mode at start: 0 full sweep, 1 skip masked-off elements |
| vlen_i | input | $clog2(VLMAX+1) | Vector length at start |
| fill_i | input | 1 | Set all mask bits |
| cmp_load_i | input | 1 | Load mask from comparison result |
| cmp_res_i | input | VLMAX | Per-element comparison outcome |
| mask_o | output | VLMAX | Current mask register |
| busy_o | output | 1 | An element is being issued this cycle |
| elem_vld_o | output | 1 | `elem_idx_o` carries an issued element |
| elem_idx_o | output | $clog2(VLMAX) | Index of the issued element |
| wr_en_o | output | 1 | Result write-enable for the issued element |
| done_o | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench aims at the edges of the sweep: a zero length and an empty mask in skip mode, where a wrong design would issue a stray element or finish late; enabled bits just above the length, which a design that ignored the length would issue; and an oversized length, which would run past the register or wrap the index. It also fires start and mask commands mid-operation, where a faulty design would restart, change mode or rewrite the mask under the running sweep, and it checks that fill beats compare-load when both arrive. A behavioural model with per-element queues is compared on every cycle, with random traffic on top of the directed cases.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_DENSE = 1'b1
  } mvx_mode_e;
endpackage

// File: rtl/mvx_mask_reg.sv
module mvx_mask_reg #(
  parameter int VLMAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             fill_i,
  input  logic             load_i,
  input  logic [VLMAX-1:0] cmp_i,
  output logic [VLMAX-1:0] mask_o
);
  logic [VLMAX-1:0] mask_q, mask_d;
  logic             mask_en;

  // fill takes priority over a compare load
  assign mask_en = ~hold_i & (fill_i | load_i);

  always_comb begin
    mask_d = mask_q;
    if (fill_i)      mask_d = '1;
    else if (load_i) mask_d = cmp_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/mvx_pick.sv
module mvx_pick #(
  parameter int VLMAX = 16,
  parameter int IDX_W = 4,
  parameter int LEN_W = 5
) (
  input  logic [VLMAX-1:0] elig_i,
  input  logic [LEN_W-1:0] from_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dense_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wen_o
);
  import mvx_pkg::*;

  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;
  logic             seq_hit;
  logic [IDX_W-1:0] seq_idx;

  // lowest enabled element at or above the search base
  always_comb begin
    scan_hit = 1'b0;
    scan_idx = '0;
    for (int i = VLMAX - 1; i >= 0; i--) begin
      if (elig_i[i] && (i >= int'(from_i))) begin
        scan_hit = 1'b1;
        scan_idx = IDX_W'(i);
      end
    end
  end

  assign seq_hit = (from_i < len_i);
  assign seq_idx = from_i[IDX_W-1:0];

  always_comb begin
    if (mvx_mode_e'(dense_i) == MODE_DENSE) begin
      found_o = scan_hit;
      idx_o   = scan_idx;
      wen_o   = scan_hit;
    end else begin
      found_o = seq_hit;
      idx_o   = seq_idx;
      wen_o   = seq_hit & elig_i[seq_idx];
    end
  end
endmodule

// File: rtl/mvx_seq.sv
module mvx_seq #(
  parameter int VLMAX = 16,
  localparam int IDX_W = $clog2(VLMAX),
  localparam int LEN_W = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             dense_i,
  input  logic [LEN_W-1:0] vlen_i,
  input  logic             fill_i,
  input  logic             cmp_load_i,
  input  logic [VLMAX-1:0] cmp_res_i,
  output logic [VLMAX-1:0] mask_o,
  output logic             busy_o,
  output logic             elem_vld_o,
  output logic [IDX_W-1:0] elem_idx_o,
  output logic             wr_en_o,
  output logic             done_o
);
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             wen_q, wen_d;
  logic             done_q, done_d;
  logic [LEN_W-1:0] len_q;
  logic             mode_q;
  logic [VLMAX-1:0] elig_q;

  logic [LEN_W-1:0] len_clamp;
  logic [VLMAX-1:0] len_bits;
  logic [VLMAX-1:0] elig_new;
  logic             accept, go;
  logic [VLMAX-1:0] sel_elig;
  logic [LEN_W-1:0] sel_from, sel_len;
  logic             sel_mode;
  logic             p_found, p_wen;
  logic [IDX_W-1:0] p_idx;

  mvx_mask_reg #(.VLMAX(VLMAX)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (vld_q),
    .fill_i (fill_i),
    .load_i (cmp_load_i),
    .cmp_i  (cmp_res_i),
    .mask_o (mask_o)
  );

  assign len_clamp = (vlen_i > LEN_W'(VLMAX)) ? LEN_W'(VLMAX) : vlen_i;

  for (genvar g = 0; g < VLMAX; g++) begin : g_len
    assign len_bits[g] = (LEN_W'(g) < len_clamp);
  end

  assign elig_new = mask_o & len_bits;
  assign accept   = start_i & ~vld_q;
  assign go       = accept | vld_q;

  assign sel_elig = accept ? elig_new  : elig_q;
  assign sel_len  = accept ? len_clamp : len_q;
  assign sel_mode = accept ? dense_i   : mode_q;
  assign sel_from = accept ? '0 : (LEN_W'(idx_q) + LEN_W'(1));

  mvx_pick #(.VLMAX(VLMAX), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_pick (
    .elig_i  (sel_elig),
    .from_i  (sel_from),
    .len_i   (sel_len),
    .dense_i (sel_mode),
    .found_o (p_found),
    .idx_o   (p_idx),
    .wen_o   (p_wen)
  );

  always_comb begin
    vld_d  = go & p_found;
    idx_d  = p_found ? p_idx : idx_q;
    wen_d  = go & p_found & p_wen;
    done_d = go & ~p_found;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      wen_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      idx_q  <= idx_d;
      wen_q  <= wen_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      mode_q <= 1'b0;
      elig_q <= '0;
    end else if (accept) begin
      len_q  <= len_clamp;
      mode_q <= dense_i;
      elig_q <= elig_new;
    end
  end

  assign busy_o     = vld_q;
  assign elem_vld_o = vld_q;
  assign elem_idx_o = idx_q;
  assign wr_en_o    = wen_q;
  assign done_o     = done_q;
endmodule

// File: rtl/mvx_seq_chk.sv
module mvx_seq_chk #(
  parameter int VLMAX = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             vld,
  input logic [IDX_W-1:0] idx,
  input logic             wen,
  input logic             done,
  input logic             fill,
  input logic [VLMAX-1:0] mask,
  input logic             run_dense
);
  AST_WEN_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n) wen |-> vld); // R11
  AST_DONE_EXCL_VLD: assert property (@(posedge clk) disable iff (!rst_n) !(done && vld)); // R11
  AST_IDX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n) vld |=> (!vld || (idx > $past(idx)))); // R5
  AST_DENSE_WRITES: assert property (@(posedge clk) disable iff (!rst_n) (vld && run_dense) |-> wen); // R6
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(mask)); // R4
  AST_FILL_SETS: assert property (@(posedge clk) disable iff (!rst_n) (fill && !busy) |=> (&mask)); // R2
endmodule

bind mvx_seq mvx_seq_chk #(.VLMAX(VLMAX), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .vld       (elem_vld_o),
  .idx       (elem_idx_o),
  .wen       (wr_en_o),
  .done      (done_o),
  .fill      (fill_i),
  .mask      (mask_o),
  .run_dense (mode_q)
);

// File: tb/sim_mvx_seq.sv
`timescale 1ns/1ps
module sim_mvx_seq;
  localparam int VL = 16;
  localparam int IW = $clog2(VL);
  localparam int LW = $clog2(VL + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0, dense_i = 1'b0, fill_i = 1'b0, cmp_load_i = 1'b0;
  logic [LW-1:0] vlen_i = '0;
  logic [VL-1:0] cmp_res_i = '0;
  logic [VL-1:0] mask_o;
  logic          busy_o, elem_vld_o, wr_en_o, done_o;
  logic [IW-1:0] elem_idx_o;

  mvx_seq #(.VLMAX(VL)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dense_i(dense_i),
    .vlen_i(vlen_i), .fill_i(fill_i), .cmp_load_i(cmp_load_i),
    .cmp_res_i(cmp_res_i), .mask_o(mask_o), .busy_o(busy_o),
    .elem_vld_o(elem_vld_o), .elem_idx_o(elem_idx_o), .wr_en_o(wr_en_o),
    .done_o(done_o)
  );

  always #2 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  int    n_issue = 0;
  int    n_wen = 0;
  int    cycles = 0;

  // behavioural reference
  logic [VL-1:0] m_mask;
  logic          m_vld, m_wen, m_done;
  int            m_idx;
  int            q_idx[$];
  bit            q_wen[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mask = '1; m_vld = 0; m_wen = 0; m_done = 0; m_idx = 0;
      q_idx.delete(); q_wen.delete();
    end else begin
      bit busy_now;
      bit go;
      busy_now = m_vld;
      go = busy_now;
      if (!busy_now && start_i) begin
        int len;
        len = (int'(vlen_i) > VL) ? VL : int'(vlen_i);
        q_idx.delete(); q_wen.delete();
        for (int i = 0; i < len; i++) begin
          if (!dense_i) begin q_idx.push_back(i); q_wen.push_back(m_mask[i]); end
          else if (m_mask[i]) begin q_idx.push_back(i); q_wen.push_back(1'b1); end
        end
        go = 1;
      end
      m_done = 0; m_vld = 0; m_wen = 0;
      if (go) begin
        if (q_idx.size() > 0) begin
          m_vld = 1; m_idx = q_idx.pop_front(); m_wen = q_wen.pop_front();
        end else m_done = 1;
      end
      if (!busy_now) begin
        if (fill_i) m_mask = '1;
        else if (cmp_load_i) m_mask = cmp_res_i;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison and issue counting
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      checks++;
      if (elem_vld_o !== m_vld || wr_en_o !== m_wen || done_o !== m_done ||
          busy_o !== m_vld || mask_o !== m_mask || (m_vld && int'(elem_idx_o) != m_idx)) begin
        errors++;
        $display("FAIL %s cycle %0d actual vld=%b idx=%0d wen=%b done=%b mask=%h expected vld=%b idx=%0d wen=%b done=%b mask=%h",
                 cur_req, cycles, elem_vld_o, elem_idx_o, wr_en_o, done_o, mask_o,
                 m_vld, m_idx, m_wen, m_done, m_mask);
      end
      if (elem_vld_o) n_issue++;
      if (wr_en_o) n_wen++;
    end
  end

  task automatic mask_cmd(input bit f, input bit l, input logic [VL-1:0] v);
    @(negedge clk);
    fill_i = f; cmp_load_i = l; cmp_res_i = v;
    @(negedge clk);
    fill_i = 0; cmp_load_i = 0;
  endtask

  task automatic run(input bit d, input int len, input string req, input int exp_issue, input int exp_wen);
    cur_req = req;
    @(negedge clk);
    start_i = 1; dense_i = d; vlen_i = LW'(len); n_issue = 0; n_wen = 0;
    @(negedge clk);
    start_i = 0;
    repeat (20) @(negedge clk);
    chk(req, "issued count", n_issue, exp_issue);
    chk(req, "write count", n_wen, exp_wen);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "vld", int'(elem_vld_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "mask", int'(mask_o), 16'hFFFF);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R3";
    mask_cmd(0, 1, 16'hA5C3);
    chk("R3", "cmp load", int'(mask_o), 16'hA5C3);
    mask_cmd(1, 1, 16'h0000);
    chk("R3", "fill beats load", int'(mask_o), 16'hFFFF);
    mask_cmd(0, 1, 16'h1234);
    cur_req = "R2";
    mask_cmd(1, 0, 16'h0000);
    chk("R2", "fill", int'(mask_o), 16'hFFFF);

    mask_cmd(0, 1, 16'hA5C3);
    run(0, 8, "R5", 8, 4);   // full sweep: low byte C3 has four ones
    run(1, 8, "R6", 4, 4);   // skip mode: only the four ones
    run(1, 5, "R7", 2, 2);   // bits 6,7 lie above the length
    run(0, 0, "R8", 0, 0);   // zero length
    mask_cmd(0, 1, 16'h0000);
    run(1, 16, "R8", 0, 0);  // empty mask in skip mode
    mask_cmd(0, 1, 16'h8001);
    run(0, 31, "R9", 16, 2); // clamped to VLMAX
    run(1, 31, "R9", 2, 2);

    // R10 and R4: commands while busy
    cur_req = "R10";
    @(negedge clk);
    start_i = 1; dense_i = 0; vlen_i = LW'(10); n_issue = 0; n_wen = 0;
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    start_i = 1; dense_i = 1; vlen_i = LW'(2); cmp_load_i = 1; cmp_res_i = 16'h00FF; fill_i = 0;
    @(negedge clk);
    start_i = 0; cmp_load_i = 0;
    chk("R4", "mask held while busy", int'(mask_o), 16'h8001);
    repeat (15) @(negedge clk);
    chk("R10", "restart ignored", n_issue, 10);
    chk("R11", "writes", n_wen, 1);

    // random traffic
    cur_req = "R6";
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      start_i    = ($urandom_range(3) == 0);
      dense_i    = $urandom_range(1);
      vlen_i     = LW'($urandom_range(31));
      fill_i     = ($urandom_range(15) == 0);
      cmp_load_i = ($urandom_range(3) == 0);
      cmp_res_i  = VL'($urandom);
    end
    @(negedge clk);
    start_i = 0; fill_i = 0; cmp_load_i = 0;
    repeat (20) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule